// File: doc/BRIEF.md
# Vector Lane Permute Unit

This block rearranges the lanes of 128-bit packed vectors. A two-bit size code divides a vector into 16 lanes of 8 bits, 8 of 16, 4 of 32 or 2 of 64. Lane 0 always sits at the least significant end. Under an opcode the unit does one of six things:

- copy a scalar into every lane;
- read one lane out as a scalar, with sign or zero extension;
- overwrite one lane of a vector;
- merge two vectors lane by lane under a bit mask;
- reorder the lanes of one vector from a list of indices;
- gather lanes from the pair of two vectors.

All of these operations share one byte-level crossbar. Any index outside its legal range raises a flag and clears the results. The results are registered by default, so each operation completes one cycle after its inputs are presented.

The unit sits in the permute slot of a vector execution pipe. Operands and immediates come from issue logic each cycle. The vector result and the scalar result return to their register files.

Top module: `vec_lane_permute`

## Requirements
- R1: With size code z (0..3), a lane is 8<<z bits wide and there are 16>>z lanes. Lane n occupies vector bits (8<<z)*n upward, so lane 0 holds the least significant bits.
- R2: Opcode 0 (broadcast) writes the low 8<<z bits of the scalar into every lane. Scalar bits above the lane width have no effect.
- R3: Opcodes 1 (unsigned extract) and 2 (signed extract) read the lane named by index entry 0 (index bits 4:0) of vector A.
  - At 8-, 16- and 32-bit lanes, the lane is widened to 32 bits: zero-extended for opcode 1, sign-extended for opcode 2. Scalar output bits 63:32 are zero.
  - At 64-bit lanes, the whole lane is returned.
  - The vector output is zero.
- R4: Opcode 3 (replace) returns A with the lane named by index entry 0 replaced by the low 8<<z bits of the scalar.
- R5: Opcode 4 (select) takes result lane i from A when mask bit i is 1 and from B otherwise. Mask bits at or above the lane count are ignored.
- R6: Opcode 5 (swizzle) sets result lane i to lane idx[i] of A, where idx[i] is index bits 5i+4:5i. Legal values are 0 to lanes-1.
- R7: Opcode 6 (shuffle) sets result lane i to lane idx[i] of A when idx[i] < lanes, and to lane idx[i]-lanes of B otherwise. Legal values are 0 to 2*lanes-1.
- R8: If any index used by the current opcode is out of range, the invalid-index flag is set and both outputs are zero. Index entries at or above the lane count are never examined.
- R9: The scalar output is zero for every opcode other than extract. The invalid-index flag is never set for broadcast, select or opcode 7.
- R10: While reset is low, all outputs are zero. Otherwise each output reflects the inputs sampled at the previous rising clock edge.
- R11: Opcode 7 (idle) drives all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Opcode |
| lsz_i | input | 2 | Lane size code |
| vec_a_i | input | 128 | Vector A (true operand of select) |
| vec_b_i | input | 128 | Vector B (false operand of select) |
| mask_i | input | 16 | Per-lane select mask |
| scl_i | input | 64 | Scalar operand |
| idx_i | input | 80 | Sixteen 5-bit lane indices, entry k at bits 5k+4:5k |
| vec_o | output | 128 | Vector result |
| scl_o | output | 64 | Scalar result |
| bad_idx_o | output | 1 | An index was out of range |

## Verification
The hardest case to reach is an index vector that is legal everywhere except one active position. Two variants make it harder: inactive entries hold out-of-range values that must be ignored, or an entry sits exactly at the lane count, which is illegal for swizzle but legal for shuffle. The stimulus covers these at every lane size:

- It moves a single bad entry across every active position.
- It fills every entry above the lane count with random values.
- It sweeps the shuffle source index over its whole legal range.
- It steps the extract and replace lane index one past the last lane.

// File: rtl/vlp_pkg.sv
package vlp_pkg;

   typedef enum logic [2:0] {
      VLP_BCAST = 3'd0,
      VLP_EXT_U = 3'd1,
      VLP_EXT_S = 3'd2,
      VLP_REPL  = 3'd3,
      VLP_SEL   = 3'd4,
      VLP_SWZ   = 3'd5,
      VLP_SHUF  = 3'd6,
      VLP_IDLE  = 3'd7
   } vlp_op_e;

   function automatic logic vlp_is_extract(logic [2:0] op);
      return (op == VLP_EXT_U) || (op == VLP_EXT_S);
   endfunction

endpackage

// File: rtl/vlp_index_check.sv
module vlp_index_check #(
   parameter int NLANE_MAX = 16,
   parameter int IDX_W     = 5,
   parameter int SZ_W      = 2
) (
   input  logic [2:0]                 op_i,
   input  logic [SZ_W-1:0]            lsz_i,
   input  logic [NLANE_MAX*IDX_W-1:0] idx_i,
   output logic                       bad_o
);
   import vlp_pkg::*;

   always_comb begin
      int lanes;
      int limit;
      lanes = NLANE_MAX >> lsz_i;
      limit = (op_i == VLP_SHUF) ? 2 * lanes : lanes;
      bad_o = 1'b0;
      case (op_i)
         VLP_EXT_U, VLP_EXT_S, VLP_REPL: begin
            bad_o = int'(idx_i[IDX_W-1:0]) >= lanes;
         end
         VLP_SWZ, VLP_SHUF: begin
            for (int k = 0; k < NLANE_MAX; k++) begin
               if (k < lanes && int'(idx_i[k*IDX_W +: IDX_W]) >= limit) begin
                  bad_o = 1'b1;
               end
            end
         end
         default: bad_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/vlp_route_ctrl.sv
module vlp_route_ctrl #(
   parameter int NB    = 16,
   parameter int SB    = 8,
   parameter int IDX_W = 5,
   parameter int SZ_W  = 2,
   parameter int SRC_W = 6
) (
   input  logic [2:0]          op_i,
   input  logic [SZ_W-1:0]     lsz_i,
   input  logic [NB-1:0]       mask_i,
   input  logic [NB*IDX_W-1:0] idx_i,
   output logic [NB*SRC_W-1:0] sel_o
);
   import vlp_pkg::*;

   localparam int NSRC     = 2 * NB + SB;
   localparam int SCL_BASE = 2 * NB;

   for (genvar j = 0; j < NB; j++) begin : g_byte
      logic [SRC_W-1:0] pick;

      always_comb begin
         int lbytes;
         int lane;
         int boff;
         int ix0;
         int ixl;
         int src;
         lbytes = 1 << lsz_i;
         lane   = j >> lsz_i;
         boff   = j & (lbytes - 1);
         ix0    = int'(idx_i[IDX_W-1:0]);
         ixl    = int'(idx_i[lane*IDX_W +: IDX_W]);
         case (op_i)
            VLP_BCAST:         src = SCL_BASE + boff;
            VLP_REPL:          src = (lane == ix0) ? SCL_BASE + boff : j;
            VLP_SEL:           src = mask_i[lane] ? j : NB + j;
            VLP_SWZ, VLP_SHUF: src = ixl * lbytes + boff;
            default:           src = j;
         endcase
         if (src >= NSRC) begin
            src = 0;
         end
         pick = SRC_W'(src);
      end

      assign sel_o[j*SRC_W +: SRC_W] = pick;
   end

endmodule

// File: rtl/vlp_byte_xbar.sv
module vlp_byte_xbar #(
   parameter int NOUT  = 16,
   parameter int NSRC  = 40,
   parameter int SRC_W = 6
) (
   input  logic [NSRC*8-1:0]     src_i,
   input  logic [NOUT*SRC_W-1:0] sel_i,
   output logic [NOUT*8-1:0]     out_o
);

   for (genvar j = 0; j < NOUT; j++) begin : g_out
      logic [SRC_W-1:0] s;
      logic [7:0]       pick;

      assign s = sel_i[j*SRC_W +: SRC_W];

      always_comb begin
         pick = 8'h00;
         for (int k = 0; k < NSRC; k++) begin
            if (int'(s) == k) begin
               pick = src_i[k*8 +: 8];
            end
         end
      end

      assign out_o[j*8 +: 8] = pick;
   end

endmodule

// File: rtl/vlp_extract.sv
module vlp_extract #(
   parameter int NB        = 16,
   parameter int SB        = 8,
   parameter int IDX_W     = 5,
   parameter int SZ_W      = 2,
   parameter int EXT_BYTES = 4
) (
   input  logic [NB*8-1:0]  a_i,
   input  logic [SZ_W-1:0]  lsz_i,
   input  logic [IDX_W-1:0] lane_i,
   input  logic             sext_i,
   output logic [SB*8-1:0]  scl_o
);

   always_comb begin
      int   lbytes;
      int   base;
      logic msb;
      lbytes = 1 << lsz_i;
      base   = int'(lane_i) * lbytes;
      msb    = 1'b0;
      if (base + lbytes <= NB) begin
         msb = a_i[(base + lbytes) * 8 - 1];
      end
      for (int k = 0; k < SB; k++) begin
         if (k < lbytes) begin
            scl_o[k*8 +: 8] = (base + k < NB) ? a_i[(base + k)*8 +: 8] : 8'h00;
         end else if (k < EXT_BYTES) begin
            scl_o[k*8 +: 8] = {8{sext_i & msb}};
         end else begin
            scl_o[k*8 +: 8] = 8'h00;
         end
      end
   end

endmodule

// File: rtl/vec_lane_permute.sv
module vec_lane_permute #(
   parameter int VEC_W      = 128,
   parameter int SCALAR_W   = 64,
   parameter int EXT_W      = 32,
   parameter bit REGISTERED = 1'b1,
   localparam int NB    = VEC_W / 8,
   localparam int SB    = SCALAR_W / 8,
   localparam int IDX_W = $clog2(2 * NB),
   localparam int SZ_W  = $clog2($clog2(SB) + 1)
) (
   input  logic                  clk_i,
   input  logic                  rst_ni,
   input  logic [2:0]            op_i,
   input  logic [SZ_W-1:0]       lsz_i,
   input  logic [VEC_W-1:0]      vec_a_i,
   input  logic [VEC_W-1:0]      vec_b_i,
   input  logic [NB-1:0]         mask_i,
   input  logic [SCALAR_W-1:0]   scl_i,
   input  logic [NB*IDX_W-1:0]   idx_i,
   output logic [VEC_W-1:0]      vec_o,
   output logic [SCALAR_W-1:0]   scl_o,
   output logic                  bad_idx_o
);
   import vlp_pkg::*;

   localparam int NSRC  = 2 * NB + SB;
   localparam int SRC_W = $clog2(NSRC);

   if (VEC_W % 8 != 0 || (NB & (NB - 1)) != 0) begin : g_chk_vec
      $error("vector width must be a power-of-two number of bytes");
   end
   if (SCALAR_W % 8 != 0 || SB > NB || (SB & (SB - 1)) != 0) begin : g_chk_scl
      $error("scalar width must be a power-of-two byte count not above the vector");
   end
   if ((1 << SZ_W) != $clog2(SB) + 1) begin : g_chk_sz
      $error("lane size code must cover exactly the sizes up to the scalar width");
   end
   if (EXT_W % 8 != 0 || EXT_W > SCALAR_W) begin : g_chk_ext
      $error("extension width must be whole bytes within the scalar");
   end

   logic                  bad;
   logic                  is_ext;
   logic                  vec_live;
   logic [NB*SRC_W-1:0]   sel;
   logic [VEC_W-1:0]      xbar_out;
   logic [SCALAR_W-1:0]   ext_out;
   logic [VEC_W-1:0]      vec_n;
   logic [SCALAR_W-1:0]   scl_n;

   vlp_index_check #(
      .NLANE_MAX (NB),
      .IDX_W     (IDX_W),
      .SZ_W      (SZ_W)
   ) u_idx (
      .op_i  (op_i),
      .lsz_i (lsz_i),
      .idx_i (idx_i),
      .bad_o (bad)
   );

   vlp_route_ctrl #(
      .NB    (NB),
      .SB    (SB),
      .IDX_W (IDX_W),
      .SZ_W  (SZ_W),
      .SRC_W (SRC_W)
   ) u_route (
      .op_i   (op_i),
      .lsz_i  (lsz_i),
      .mask_i (mask_i),
      .idx_i  (idx_i),
      .sel_o  (sel)
   );

   vlp_byte_xbar #(
      .NOUT  (NB),
      .NSRC  (NSRC),
      .SRC_W (SRC_W)
   ) u_xbar (
      .src_i ({scl_i, vec_b_i, vec_a_i}),
      .sel_i (sel),
      .out_o (xbar_out)
   );

   vlp_extract #(
      .NB        (NB),
      .SB        (SB),
      .IDX_W     (IDX_W),
      .SZ_W      (SZ_W),
      .EXT_BYTES (EXT_W / 8)
   ) u_ext (
      .a_i    (vec_a_i),
      .lsz_i  (lsz_i),
      .lane_i (idx_i[IDX_W-1:0]),
      .sext_i (op_i == VLP_EXT_S),
      .scl_o  (ext_out)
   );

   assign is_ext   = vlp_is_extract(op_i);
   assign vec_live = !bad && !is_ext && (op_i != VLP_IDLE);
   assign vec_n    = vec_live ? xbar_out : '0;
   assign scl_n    = (is_ext && !bad) ? ext_out : '0;

   if (REGISTERED) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            vec_o     <= '0;
            scl_o     <= '0;
            bad_idx_o <= 1'b0;
         end else begin
            vec_o     <= vec_n;
            scl_o     <= scl_n;
            bad_idx_o <= bad;
         end
      end
   end else begin : g_comb
      assign vec_o     = vec_n;
      assign scl_o     = scl_n;
      assign bad_idx_o = bad;
   end

endmodule

// File: rtl/vlp_chk.sv
module vlp_chk #(
   parameter int VEC_W      = 128,
   parameter int SCALAR_W   = 64,
   parameter bit REGISTERED = 1'b1,
   localparam int NB   = VEC_W / 8,
   localparam int SZ_W = $clog2($clog2(SCALAR_W / 8) + 1)
) (
   input logic                clk_i,
   input logic                rst_ni,
   input logic [2:0]          op_i,
   input logic [SZ_W-1:0]     lsz_i,
   input logic [VEC_W-1:0]    vec_a_i,
   input logic [VEC_W-1:0]    vec_b_i,
   input logic [NB-1:0]       mask_i,
   input logic [7:0]          scl_lo_i,
   input logic [VEC_W-1:0]    vec_o,
   input logic [SCALAR_W-1:0] scl_o,
   input logic                bad_idx_o
);
   import vlp_pkg::*;

   if (REGISTERED) begin : g_props
      AST_BAD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
         bad_idx_o |-> (vec_o == '0 && scl_o == '0)); // R8

      AST_EXT_VEC_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ($past(rst_ni) && vlp_is_extract($past(op_i))) |-> vec_o == '0); // R3

      AST_SCL_ONLY_EXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ($past(rst_ni) && !vlp_is_extract($past(op_i))) |-> scl_o == '0); // R9

      AST_NO_FLAG_UNINDEXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ($past(rst_ni) && ($past(op_i) == VLP_BCAST || $past(op_i) == VLP_SEL ||
                            $past(op_i) == VLP_IDLE)) |-> !bad_idx_o); // R9

      AST_SEL_ALL_TRUE: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ($past(rst_ni) && $past(op_i) == VLP_SEL && $past(mask_i) == '1)
            |-> vec_o == $past(vec_a_i)); // R5

      AST_SEL_ALL_FALSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ($past(rst_ni) && $past(op_i) == VLP_SEL && $past(mask_i) == '0)
            |-> vec_o == $past(vec_b_i)); // R5

      AST_BCAST_BYTES: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ($past(rst_ni) && $past(op_i) == VLP_BCAST && $past(lsz_i) == '0)
            |-> vec_o == {NB{$past(scl_lo_i)}}); // R2

      AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
         ($past(rst_ni) && $past(op_i) == VLP_IDLE)
            |-> (vec_o == '0 && scl_o == '0)); // R11

      AST_RESET_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
         $past(!rst_ni) |-> (vec_o == '0 && scl_o == '0 && !bad_idx_o)); // R10
   end

endmodule

bind vec_lane_permute vlp_chk #(
   .VEC_W      (VEC_W),
   .SCALAR_W   (SCALAR_W),
   .REGISTERED (REGISTERED)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .op_i      (op_i),
   .lsz_i     (lsz_i),
   .vec_a_i   (vec_a_i),
   .vec_b_i   (vec_b_i),
   .mask_i    (mask_i),
   .scl_lo_i  (scl_i[7:0]),
   .vec_o     (vec_o),
   .scl_o     (scl_o),
   .bad_idx_o (bad_idx_o)
);

// File: tb/sim_vec_lane_permute.sv
module sim_vec_lane_permute;
   timeunit 1ns;
   timeprecision 1ps;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [2:0]   op;
   logic [1:0]   lsz;
   logic [127:0] va, vb;
   logic [15:0]  mask;
   logic [63:0]  scl;
   logic [79:0]  idx;
   logic [127:0] vec_o;
   logic [63:0]  scl_o;
   logic         bad_o;

   int n_chk = 0;
   int n_bad = 0;

   always #2.5 clk = ~clk;

   vec_lane_permute u0 (
      .clk_i     (clk),
      .rst_ni    (rst_n),
      .op_i      (op),
      .lsz_i     (lsz),
      .vec_a_i   (va),
      .vec_b_i   (vb),
      .mask_i    (mask),
      .scl_i     (scl),
      .idx_i     (idx),
      .vec_o     (vec_o),
      .scl_o     (scl_o),
      .bad_idx_o (bad_o)
   );

   function automatic logic [63:0] get_lane(logic [127:0] v, int i, int lb);
      logic [63:0] r = '0;
      for (int k = 0; k < lb; k++) r[k] = v[i*lb + k];
      return r;
   endfunction

   function automatic logic [127:0] put_lane(logic [127:0] v, int i, int lb, logic [63:0] x);
      for (int k = 0; k < lb; k++) v[i*lb + k] = x[k];
      return v;
   endfunction

   function automatic logic [79:0] set_ix(logic [79:0] ix, int p, int v);
      ix[p*5 +: 5] = v[4:0];
      return ix;
   endfunction

   function automatic logic [127:0] r128();
      return {$urandom, $urandom, $urandom, $urandom};
   endfunction

   function automatic logic [63:0] r64();
      return {$urandom, $urandom};
   endfunction

   function automatic logic [79:0] rix_all();
      logic [79:0] ix;
      for (int k = 0; k < 16; k++) ix[k*5 +: 5] = 5'($urandom % 32);
      return ix;
   endfunction

   // random legal entries below ln, random junk above
   function automatic logic [79:0] rix(int ln, int lim);
      logic [79:0] ix = rix_all();
      for (int k = 0; k < ln; k++) ix = set_ix(ix, k, int'($urandom % lim));
      return ix;
   endfunction

   function automatic void model(input logic [2:0] o, input logic [1:0] sz,
                                 input logic [127:0] a, input logic [127:0] b,
                                 input logic [15:0] m, input logic [63:0] s,
                                 input logic [79:0] ix, output logic [127:0] ev,
                                 output logic [63:0] es, output logic eb);
      int lb, ln, i0, v, lim;
      logic [63:0] t;
      lb = 8 << sz; ln = 16 >> sz;
      ev = '0; es = '0; eb = 1'b0;
      i0 = int'(ix[4:0]);
      case (o)
         3'd0: for (int i = 0; i < ln; i++) ev = put_lane(ev, i, lb, s);
         3'd1, 3'd2: begin
            if (i0 >= ln) eb = 1'b1;
            else begin
               t = get_lane(a, i0, lb);
               if (o == 3'd2 && lb < 32 && t[lb-1])
                  t = t | (64'hFFFF_FFFF & ~((64'd1 << lb) - 64'd1));
               es = t;
            end
         end
         3'd3: begin
            if (i0 >= ln) eb = 1'b1;
            else ev = put_lane(a, i0, lb, s);
         end
         3'd4: for (int i = 0; i < ln; i++)
            ev = put_lane(ev, i, lb, m[i] ? get_lane(a, i, lb) : get_lane(b, i, lb));
         3'd5, 3'd6: begin
            lim = (o == 3'd6) ? 2 * ln : ln;
            for (int i = 0; i < ln; i++) begin
               v = int'(ix[i*5 +: 5]);
               if (v >= lim) eb = 1'b1;
               else ev = put_lane(ev, i, lb, (v < ln) ? get_lane(a, v, lb)
                                                     : get_lane(b, v - ln, lb));
            end
         end
         default: ;
      endcase
      if (eb) begin
         ev = '0;
         es = '0;
      end
   endfunction

   task automatic apply(input logic [2:0] o, input logic [1:0] sz, input logic [127:0] a,
                        input logic [127:0] b, input logic [15:0] m, input logic [63:0] s,
                        input logic [79:0] ix, input string tag);
      logic [127:0] ev;
      logic [63:0]  es;
      logic         eb;
      @(negedge clk);
      op = o; lsz = sz; va = a; vb = b; mask = m; scl = s; idx = ix;
      model(o, sz, a, b, m, s, ix, ev, es, eb);
      @(negedge clk);
      n_chk++;
      if (vec_o !== ev || scl_o !== es || bad_o !== eb) begin
         n_bad++;
         $display("FAIL %s op=%0d sz=%0d got vec=%h scl=%h bad=%b exp vec=%h scl=%h bad=%b",
                  tag, o, sz, vec_o, scl_o, bad_o, ev, es, eb);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL R10 watchdog got=running exp=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      logic [127:0] pat;
      logic [79:0]  ix;
      int           ln;
      op = 3'd3; lsz = 2'd0; va = '1; vb = '1; mask = '1; scl = '1; idx = '0;
      repeat (3) @(negedge clk);
      n_chk++; // R10: outputs clear while reset is held
      if (vec_o !== '0 || scl_o !== '0 || bad_o !== 1'b0) begin
         n_bad++;
         $display("FAIL R10 reset got vec=%h scl=%h bad=%b exp all zero", vec_o, scl_o, bad_o);
      end
      rst_n = 1'b1;

      // R1: byte-numbered pattern through identity swizzle keeps lane order
      for (int j = 0; j < 16; j++) pat[j*8 +: 8] = 8'(j);
      for (int k = 0; k < 16; k++) ix[k*5 +: 5] = 5'(k);
      apply(3'd5, 2'd0, pat, '0, '0, '0, ix, "R1");
      apply(3'd1, 2'd1, pat, '0, '0, '0, set_ix(ix, 0, 5), "R1");

      for (int sz = 0; sz < 4; sz++) begin
         ln = 16 >> sz;
         for (int r = 0; r < 4; r++)
            apply(3'd0, 2'(sz), r128(), r128(), '1, r64(), rix_all(), (r == 0) ? "R9" : "R2");
         for (int r = 0; r < 3; r++) begin
            for (int e = 0; e <= ln; e++) begin
               pat = r128();
               if (r == 0) pat = pat | {16{8'h80}};
               ix = set_ix(rix_all(), 0, e);
               apply(3'd1, 2'(sz), pat, r128(), '0, r64(), ix, (e < ln) ? "R3" : "R8");
               apply(3'd2, 2'(sz), pat, r128(), '0, r64(), ix, (e < ln) ? "R3" : "R8");
            end
         end
         for (int e = 0; e <= ln; e++)
            apply(3'd3, 2'(sz), r128(), r128(), '0, r64(), set_ix(rix_all(), 0, e),
                  (e < ln) ? "R4" : "R8");
         apply(3'd4, 2'(sz), r128(), r128(), 16'h0000, r64(), rix_all(), "R5");
         apply(3'd4, 2'(sz), r128(), r128(), 16'hFFFF, r64(), rix_all(), "R5");
         for (int r = 0; r < 4; r++)
            apply(3'd4, 2'(sz), r128(), r128(), 16'($urandom), r64(), rix_all(), "R5");
         ix = rix_all();
         for (int k = 0; k < ln; k++) ix = set_ix(ix, k, k);
         apply(3'd5, 2'(sz), r128(), r128(), '0, r64(), ix, "R6");
         for (int k = 0; k < ln; k++) ix = set_ix(ix, k, ln - 1 - k);
         apply(3'd5, 2'(sz), r128(), r128(), '0, r64(), ix, "R6");
         for (int r = 0; r < 6; r++)
            apply(3'd5, 2'(sz), r128(), r128(), '0, r64(), rix(ln, ln), "R6");
         for (int p = 0; p < ln; p++)
            apply(3'd5, 2'(sz), r128(), r128(), '0, r64(), set_ix(rix(ln, ln), p, ln), "R8");
         for (int v = 0; v < 2 * ln; v++)
            apply(3'd6, 2'(sz), r128(), r128(), '0, r64(), set_ix(rix(ln, 2 * ln), 0, v), "R7");
         for (int r = 0; r < 4; r++)
            apply(3'd6, 2'(sz), r128(), r128(), '0, r64(), rix(ln, 2 * ln), "R7");
         if (2 * ln < 32)
            for (int p = 0; p < ln; p++)
               apply(3'd6, 2'(sz), r128(), r128(), '0, r64(),
                     set_ix(rix(ln, 2 * ln), p, 2 * ln), "R8");
         apply(3'd7, 2'(sz), r128(), r128(), 16'($urandom), r64(), rix_all(), "R11");
      end

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule